// File: doc/BRIEF.md
# Line-Based Command Receiver

This block sits behind a serial byte receiver and turns short text lines into a single display-mode setting. Each received byte comes in with a one-cycle valid. The bytes are gathered into a line of bounded length, but only the first character of a line and the number of characters held so far are kept. Those are all the decoding needs.

A line ends on a newline, but only once at least four characters are already held. A shorter line takes the newline as an ordinary character. When a line ends, its first character sets the mode bit (`A`), clears it (`C`), or is ignored. In every case the line is discarded. An escape byte restarts the line at any time and becomes its first character. A byte that arrives when the line is already full discards the line silently. Only an escape byte survives this, becoming the first character of a fresh line. A downstream filter reads the mode bit, and a one-cycle strobe marks every write to it.

Top module: `cmd_line_rx`

## Requirements
- R1: After synchronous reset the mode bit is 0, the strobe is 0 and the line holds no characters.
- R2: An accepted escape byte (0x1B) empties the line and is kept as its first character, with a count of one, even when the line was full.
- R3: An accepted newline (0x0A) ends the line only when more than MIN_LEN (default 3) characters are held and the line is not full. Otherwise it is held as an ordinary character.
- R4: When a line ends with first character 0x41 (`A`), the mode bit becomes 1 on the clock edge that accepts the newline.
- R5: When a line ends with first character 0x43 (`C`), the mode bit becomes 0 on that edge. The strobe fires even if the bit was already 0.
- R6: A line that ends with any other first character leaves the mode bit unchanged and gives no strobe. In every case, an ended line leaves the buffer empty.
- R7: A non-escape byte accepted while DEPTH characters are held empties the line and is dropped. This applies to a newline too, which then ends no line.
- R8: The strobe is high for exactly the one cycle after the edge that wrote the mode bit, and the mode bit changes at no other time.
- R9: While the valid input is low, the data input has no effect on the line or on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid_i | input | 1 | Byte on rx_data_i is valid this cycle |
| rx_data_i | input | 8 | Received byte |
| live_mode_o | output | 1 | Display mode bit (1 = show all) |
| mode_wr_o | output | 1 | One-cycle pulse each time the mode bit is written |

## Verification
The hardest cases to reach are the full-line boundaries. Driving a line to exactly DEPTH characters and then offering an escape, a newline or a command letter separates the overflow rule from the normal path. The bench runs at DEPTH 8 so these states come quickly. The follow-up lines are chosen so that a wrongly kept or dropped byte changes whether a later command takes effect. The newline threshold gets the same treatment: a newline arrives after exactly three characters and then again after four.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

    localparam logic [7:0] CH_ESC = 8'h1B;
    localparam logic [7:0] CH_EOL = 8'h0A;
    localparam logic [7:0] CH_SET = 8'h41;
    localparam logic [7:0] CH_CLR = 8'h43;

    typedef enum logic [1:0] {
        BK_PLAIN = 2'd0,
        BK_ESC   = 2'd1,
        BK_EOL   = 2'd2
    } byte_kind_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } mode_act_e;

    typedef struct packed {
        logic       done;
        logic [7:0] first;
    } line_evt_t;

    function automatic byte_kind_e kind_of(input logic [7:0] b);
        if (b == CH_ESC)      return BK_ESC;
        else if (b == CH_EOL) return BK_EOL;
        else                  return BK_PLAIN;
    endfunction

    function automatic mode_act_e act_of(input logic [7:0] first);
        if (first == CH_SET)      return ACT_SET;
        else if (first == CH_CLR) return ACT_CLR;
        else                      return ACT_NONE;
    endfunction

endpackage

// File: rtl/cmd_rx_classify.sv
module cmd_rx_classify
    import cmd_rx_pkg::*;
(
    input  logic [7:0]  data_i,
    output byte_kind_e  kind_o
);
    always_comb begin
        kind_o = kind_of(data_i);
    end
endmodule

// File: rtl/cmd_rx_linebuf.sv
module cmd_rx_linebuf
    import cmd_rx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MIN_LEN = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [7:0]  data_i,
    input  byte_kind_e  kind_i,
    output line_evt_t   evt_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] END_CNT  = CW'(MIN_LEN);

    logic [CW-1:0] cnt_q;
    logic [7:0]    first_q;
    logic          full;
    logic          finish;

    assign full   = (cnt_q == FULL_CNT);
    assign finish = valid_i && !full && (kind_i == BK_EOL) && (cnt_q > END_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            first_q <= '0;
        end else if (valid_i) begin
            if (kind_i == BK_ESC) begin
                cnt_q   <= CW'(1);
                first_q <= data_i;
            end else if (full || finish) begin
                cnt_q <= '0;
            end else begin
                if (cnt_q == '0) first_q <= data_i;
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign evt_o.done  = finish;
    assign evt_o.first = first_q;

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

    assert_esc_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && data_i == CH_ESC) |=> (cnt_q == CW'(1) && first_q == CH_ESC));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(cnt_q) && $stable(first_q)));

    assert_overflow_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && full && data_i != CH_ESC) |=> (cnt_q == '0));
endmodule

// File: rtl/cmd_rx_mode_reg.sv
module cmd_rx_mode_reg
    import cmd_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_evt_t  evt_i,
    output logic       mode_o,
    output logic       wr_o
);
    mode_act_e act;

    always_comb begin
        act = evt_i.done ? act_of(evt_i.first) : ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= 1'b0;
            wr_o   <= 1'b0;
        end else begin
            wr_o <= (act != ACT_NONE);
            if (act == ACT_SET)      mode_o <= 1'b1;
            else if (act == ACT_CLR) mode_o <= 1'b0;
        end
    end

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        wr_o |=> !wr_o);

    assert_mode_needs_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |-> wr_o);
endmodule

// File: rtl/cmd_line_rx.sv
module cmd_line_rx
    import cmd_rx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MIN_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    output logic       live_mode_o,
    output logic       mode_wr_o
);
    byte_kind_e kind;
    line_evt_t  evt;

    cmd_rx_classify u_classify (
        .data_i (rx_data_i),
        .kind_o (kind)
    );

    cmd_rx_linebuf #(
        .DEPTH   (DEPTH),
        .MIN_LEN (MIN_LEN)
    ) u_linebuf (
        .clk     (clk),
        .rst     (rst),
        .valid_i (rx_valid_i),
        .data_i  (rx_data_i),
        .kind_i  (kind),
        .evt_o   (evt)
    );

    cmd_rx_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .mode_o (live_mode_o),
        .wr_o   (mode_wr_o)
    );

    assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (rst)
        mode_wr_o |-> $past(rx_valid_i && rx_data_i == CH_EOL));

    assert_set_on_a_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_wr_o && $past(evt.first) == CH_SET) |-> live_mode_o);

    assert_clr_on_c_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_wr_o && $past(evt.first) == CH_CLR) |-> !live_mode_o);
endmodule

// File: tb/tb_cmd_line_rx.sv
module tb_cmd_line_rx;
    localparam int DEPTH   = 8;
    localparam int MIN_LEN = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = 8'h00;
    logic       live_mode_o;
    logic       mode_wr_o;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    int cycles = 0;

    // behavioural reference state
    int m_cnt = 0;
    int m_first = 0;
    int m_mode = 0;
    int m_wr = 0;

    always #2.5 clk = ~clk;

    cmd_line_rx #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN)) dut (
        .clk         (clk),
        .rst         (rst),
        .rx_valid_i  (rx_valid_i),
        .rx_data_i   (rx_data_i),
        .live_mode_o (live_mode_o),
        .mode_wr_o   (mode_wr_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_first = 0; m_mode = 0; m_wr = 0;
        end else begin
            m_wr = 0;
            if (rx_valid_i) begin
                int b;
                b = rx_data_i;
                if (b == 27) begin
                    m_cnt = 1; m_first = 27;
                end else if (m_cnt == DEPTH) begin
                    m_cnt = 0;
                end else if (b == 10 && m_cnt > MIN_LEN) begin
                    if (m_first == 65) begin m_mode = 1; m_wr = 1; end
                    else if (m_first == 67) begin m_mode = 0; m_wr = 1; end
                    m_cnt = 0;
                end else begin
                    if (m_cnt == 0) m_first = b;
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (mode_wr_o) strobes++;
            checks++;
            if (live_mode_o !== (m_mode != 0)) begin
                failures++;
                $display("FAIL R4 cycle mode: actual=%0b expected=%0d", live_mode_o, m_mode);
            end
            checks++;
            if (mode_wr_o !== (m_wr != 0)) begin
                failures++;
                $display("FAIL R8 cycle strobe: actual=%0b expected=%0d", mode_wr_o, m_wr);
            end
        end
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_data_i  = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send(s[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input logic exp_mode, input int exp_strobes);
        idle(2);
        checks++;
        if (live_mode_o !== exp_mode || strobes != exp_strobes) begin
            failures++;
            $display("FAIL %s: actual mode=%0b strobes=%0d expected mode=%0b strobes=%0d",
                     tag, live_mode_o, strobes, exp_mode, exp_strobes);
        end
        strobes = 0;
    endtask

    initial begin
        idle(3);
        checks++;
        if (live_mode_o !== 1'b0 || mode_wr_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: actual mode=%0b wr=%0b expected 0 0", live_mode_o, mode_wr_o);
        end
        @(negedge clk); rst = 1'b0;
        strobes = 0;
        expect_state("R1 idle after reset", 1'b0, 0);

        send_str("Axyz\n");
        expect_state("R4 set on A", 1'b1, 1);

        send_str("Cab\n");
        expect_state("R3 short newline stored", 1'b1, 0);
        send(8'h0A);
        expect_state("R3 newline after four ends line", 1'b0, 1);

        send_str("Cxxx\n");
        expect_state("R5 clear repeats strobe", 1'b0, 1);

        send_str("Zxxx\n");
        expect_state("R6 other first char", 1'b0, 0);
        send_str("Aqqq\n");
        expect_state("R6 buffer empty after line", 1'b1, 1);

        send_str("Cxx");
        send(8'h1B);
        send_str("xxx\n");
        expect_state("R2 escape restarts line", 1'b1, 0);
        send_str("Cqqq\n");
        expect_state("R2 next line clean", 1'b0, 1);

        send_str("Axxxxxxx");
        send(8'h0A);
        expect_state("R7 newline on full dropped", 1'b0, 0);
        send_str("bbbb\n");
        expect_state("R7 empty after overflow", 1'b0, 0);

        send_str("Cxxxxxxx");
        send(8'h41);
        send_str("bbbb\n");
        expect_state("R7 letter on full dropped", 1'b0, 0);

        send_str("Axxxxxxx");
        send(8'h1B);
        send_str("yyy\n");
        expect_state("R2 escape kept on overflow", 1'b0, 0);
        send_str("Azzz\n");
        expect_state("R2 line after escape overflow", 1'b1, 1);

        send_str("Cxxx");
        rx_data_i = 8'h0A;
        idle(4);
        rx_data_i = 8'h1B;
        idle(3);
        expect_state("R9 invalid bytes ignored", 1'b1, 0);
        send(8'h0A);
        expect_state("R9 line intact after idle", 1'b0, 1);

        send_str("Ab\ncd\n");
        expect_state("R3 stored newline counted", 1'b1, 1);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule